// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker with Palette Lookup

This block sits between a frame buffer fetch engine and the pixel processing stages of a flat panel display path. It accepts 32-bit words of packed, encoded pixel data and cuts each word into pixels of a programmable depth: 1, 2, 4, 8 or 16 bits. Pixels are taken starting at bit 0 of the word, so a word carries 32, 16, 8, 4 or 2 of them.

Pixels of 8 bits or fewer are indexes into a 256-entry, 16-bit colour table held in on-chip RAM. The looked-up entry goes to the temporal dither stage. Pixels of 16 bits skip the table. For a passive panel they still go to the dither stage. For an active panel they go straight to the panel data path. A monochrome setting keeps only the low 8 bits of each table entry. The table is written through its own port, and only between frames. A write that arrives while a frame is in progress waits until a start-of-frame pulse ends that frame.

Both outputs use a valid/ready handshake, and a stall holds the whole pipeline without losing or repeating a pixel.

Top module: `fbpix_unpack`

## Requirements
- R1: `depth_sel` selects the pixel depth: 0 for 1 bit, 1 for 2 bits, 2 for 4 bits, 3 for 8 bits and 4 for 16 bits. Pixels leave in order of rising bit position within a word, and words leave in the order they were accepted.
- R2: A pixel of 1, 2 or 4 bits is zero-extended to form the table index. It can therefore reach only entries 0–1, 0–3 or 0–15 respectively. An 8-bit pixel can reach any of the 256 entries.
- R3: For depths up to 8 bits, the value on `dith_data` is the 16-bit table entry that the pixel indexes.
- R4: When `mono` is 1, a looked-up value has bits 15:8 forced to zero and keeps bits 7:0 of the entry.
- R5: At 16-bit depth with `panel_active` = 0, the raw pixel appears unchanged on the dither output.
- R6: At 16-bit depth with `panel_active` = 1, the raw pixel appears on the panel output, and the dither output never becomes valid.
- R7: Looked-up pixels always go to the dither output, whatever the value of `panel_active`. `pan_valid` is asserted only at 16-bit depth on an active panel.
- R8: While an output is valid and its ready input is low, the valid and the data hold steady. No pixel is dropped or duplicated under any pattern of ready.
- R9: Accepting a frame buffer word starts a frame. From the next cycle, `pal_wr_ready` is low and table writes are held off. A `sof` pulse ends the frame, so `pal_wr_ready` is high in the cycle after it. A write takes effect on an edge where `pal_wr_en` and `pal_wr_ready` are both high.
- R10: After reset, both output valids are low, and `word_ready` and `pal_wr_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse; ends the current frame |
| depth_sel | input | 3 | Pixel depth code (0:1, 1:2, 2:4, 3:8, 4:16 bits) |
| panel_active | input | 1 | 1 = active panel, 0 = passive panel |
| mono | input | 1 | Monochrome: keep only the low 8 bits of table entries |
| word_valid | input | 1 | Frame buffer word available |
| word_data | input | 32 | Packed pixel word |
| word_ready | output | 1 | Word accepted on this edge when valid |
| pal_wr_en | input | 1 | Table write request |
| pal_wr_addr | input | 8 | Table write index |
| pal_wr_data | input | 16 | Table write value |
| pal_wr_ready | output | 1 | Table write accepted on this edge when requested |
| dith_valid | output | 1 | Pixel valid toward the dither stage |
| dith_data | output | 16 | Pixel value toward the dither stage |
| dith_ready | input | 1 | Dither stage can take a pixel |
| pan_valid | output | 1 | Pixel valid toward the panel data path |
| pan_data | output | 16 | Raw 16-bit pixel toward the panel |
| pan_ready | input | 1 | Panel path can take a pixel |

## Verification
The table is loaded with a distinct value in every entry, so each looked-up pixel shows which index was formed.

- Words of all ones at 1, 2 and 4 bits show whether the index is confined to the lowest entries. An index that is not confined would land on entry 255 instead.
- Mixed nibble and byte patterns at 4 and 8 bits separate extraction that starts at bit 0 from the reverse order.
- 16-bit words are sent on both panel types, and an 8-bit run is sent with `panel_active` high. Together these separate the two bypass routes from the table route.
- A pseudo-random ready pattern over back-to-back words exposes dropped, repeated or changed pixels during stalls.
- A write attempted mid-frame, followed by a read of the same entry before and after `sof`, shows whether the write was held off.

// File: rtl/fbpix_pkg.sv
package fbpix_pkg;

  typedef enum logic [2:0] {
    DEPTH_1  = 3'd0,
    DEPTH_2  = 3'd1,
    DEPTH_4  = 3'd2,
    DEPTH_8  = 3'd3,
    DEPTH_16 = 3'd4
  } depth_e;

  // log2 of the pixel width; codes above the 16-bit one are treated as 16-bit
  function automatic logic [2:0] depth_log2(input logic [2:0] code);
    return (code > DEPTH_16) ? DEPTH_16 : code;
  endfunction

endpackage

// File: rtl/fbpix_slicer.sv
module fbpix_slicer #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        lg_bpp,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  input  logic              pix_take
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word_q;
  logic              full_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  shamt;
  logic [CNT_W:0]    wbits;
  logic [WORD_W-1:0] shifted;
  logic [PIX_W-1:0]  mask;
  logic              last;

  always_comb begin
    last_idx = CNT_W'((WORD_W >> lg_bpp) - 1);
    shamt    = idx_q << lg_bpp;
    wbits    = (CNT_W+1)'(1) << lg_bpp;
    shifted  = word_q >> shamt;
    mask     = ~({PIX_W{1'b1}} << wbits);
    pix_data = shifted[PIX_W-1:0] & mask;
    last     = (idx_q == last_idx);
  end

  assign pix_valid  = full_q;
  assign word_ready = !full_q || (pix_take && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      idx_q  <= '0;
    end else if (word_valid && word_ready) begin
      word_q <= word_data;
      full_q <= 1'b1;
      idx_q  <= '0;
    end else if (pix_take && full_q) begin
      if (last) full_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/fbpix_palette.sv
module fbpix_palette #(
  parameter int ENTRIES = 256,
  parameter int ENTRY_W = 16,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [AW-1:0]      raddr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fbpix_unpack.sv
module fbpix_unpack #(
  parameter int WORD_W      = 32,
  parameter int PAL_ENTRIES = 256,
  parameter int PAL_W       = 16,
  parameter int MONO_W      = 8,
  parameter int PAL_AW      = $clog2(PAL_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic [2:0]        depth_sel,
  input  logic              panel_active,
  input  logic              mono,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              pal_wr_en,
  input  logic [PAL_AW-1:0] pal_wr_addr,
  input  logic [PAL_W-1:0]  pal_wr_data,
  output logic              pal_wr_ready,
  output logic              dith_valid,
  output logic [PAL_W-1:0]  dith_data,
  input  logic              dith_ready,
  output logic              pan_valid,
  output logic [PAL_W-1:0]  pan_data,
  input  logic              pan_ready
);
  import fbpix_pkg::*;

  logic [2:0]       lg;
  logic             direct;
  logic             pix_valid;
  logic [PAL_W-1:0] pix_data;
  logic             adv;
  logic             issue;
  logic             out_v_q, to_panel_q, use_pal_q, mono_q;
  logic [PAL_W-1:0] byp_q;
  logic [PAL_W-1:0] pal_rdata;
  logic             frame_on_q;

  assign lg     = depth_log2(depth_sel);
  assign direct = (lg == DEPTH_16);

  fbpix_slicer #(.WORD_W(WORD_W), .PIX_W(PAL_W)) slicer_i (
    .clk(clk), .rst(rst), .lg_bpp(lg),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_take(adv)
  );

  // output stage moves when empty or when its selected consumer takes the pixel
  assign adv   = !out_v_q || (to_panel_q ? pan_ready : dith_ready);
  assign issue = pix_valid && adv;

  fbpix_palette #(.ENTRIES(PAL_ENTRIES), .ENTRY_W(PAL_W), .AW(PAL_AW)) pal_i (
    .clk(clk),
    .we(pal_wr_en && pal_wr_ready), .waddr(pal_wr_addr), .wdata(pal_wr_data),
    .re(issue), .raddr(pix_data[PAL_AW-1:0]), .rdata(pal_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v_q    <= 1'b0;
      to_panel_q <= 1'b0;
      use_pal_q  <= 1'b0;
      mono_q     <= 1'b0;
    end else if (adv) begin
      out_v_q    <= pix_valid;
      to_panel_q <= direct && panel_active;
      use_pal_q  <= !direct;
      mono_q     <= mono;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) byp_q <= pix_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                           frame_on_q <= 1'b0;
    else if (word_valid && word_ready) frame_on_q <= 1'b1;
    else if (sof)                      frame_on_q <= 1'b0;
  end

  assign pal_wr_ready = !frame_on_q;

  always_comb begin
    if (!use_pal_q)  dith_data = byp_q;
    else if (mono_q) dith_data = {{(PAL_W-MONO_W){1'b0}}, pal_rdata[MONO_W-1:0]};
    else             dith_data = pal_rdata;
  end

  assign dith_valid = out_v_q && !to_panel_q;
  assign pan_valid  = out_v_q && to_panel_q;
  assign pan_data   = byp_q;
endmodule

// File: rtl/fbpix_unpack_chk.sv
module fbpix_unpack_chk #(
  parameter int PAL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sof,
  input logic [2:0]       depth_sel,
  input logic             panel_active,
  input logic             word_valid,
  input logic             word_ready,
  input logic             pal_wr_ready,
  input logic             dith_valid,
  input logic [PAL_W-1:0] dith_data,
  input logic             dith_ready,
  input logic             pan_valid,
  input logic [PAL_W-1:0] pan_data,
  input logic             pan_ready
);
  // R8
  dith_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dith_valid && !dith_ready |=> dith_valid && $stable(dith_data));

  // R8
  pan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pan_valid && !pan_ready |=> pan_valid && $stable(pan_data));

  // R7
  pan_route_chk: assert property (@(posedge clk) disable iff (rst)
    pan_valid |-> (depth_sel >= 3'd4) && panel_active);

  // R6
  no_dith_active16_chk: assert property (@(posedge clk) disable iff (rst)
    (depth_sel >= 3'd4) && panel_active |-> !dith_valid);

  // R9
  frame_lock_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid && word_ready |=> !pal_wr_ready);

  // R9
  frame_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    sof && !(word_valid && word_ready) |=> pal_wr_ready);

  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dith_valid && !pan_valid && word_ready && pal_wr_ready);
endmodule

bind fbpix_unpack fbpix_unpack_chk #(.PAL_W(PAL_W)) chk_i (
  .clk(clk), .rst(rst), .sof(sof), .depth_sel(depth_sel),
  .panel_active(panel_active), .word_valid(word_valid), .word_ready(word_ready),
  .pal_wr_ready(pal_wr_ready), .dith_valid(dith_valid), .dith_data(dith_data),
  .dith_ready(dith_ready), .pan_valid(pan_valid), .pan_data(pan_data),
  .pan_ready(pan_ready)
);

// File: tb/fbpix_unpack_tb_top.sv
module fbpix_unpack_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof = 1'b0;
  logic [2:0]  depth_sel = 3'd3;
  logic        panel_active = 1'b0;
  logic        mono = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        pal_wr_en = 1'b0;
  logic [7:0]  pal_wr_addr = '0;
  logic [15:0] pal_wr_data = '0;
  logic        pal_wr_ready;
  logic        dith_valid, pan_valid;
  logic [15:0] dith_data, pan_data;
  logic        dith_ready = 1'b1;
  logic        pan_ready = 1'b1;

  always #5 clk = ~clk;

  fbpix_unpack dut_i (
    .clk(clk), .rst(rst), .sof(sof), .depth_sel(depth_sel),
    .panel_active(panel_active), .mono(mono),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .pal_wr_en(pal_wr_en), .pal_wr_addr(pal_wr_addr), .pal_wr_data(pal_wr_data),
    .pal_wr_ready(pal_wr_ready),
    .dith_valid(dith_valid), .dith_data(dith_data), .dith_ready(dith_ready),
    .pan_valid(pan_valid), .pan_data(pan_data), .pan_ready(pan_ready)
  );

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";
  logic [15:0] pal_m [256];
  logic [15:0] exp_d [$];
  logic [15:0] exp_p [$];
  logic        stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        hold_d = 1'b0, hold_p = 1'b0;
  logic [15:0] hold_dv, hold_pv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sync();
    @(posedge clk); #1;
  endtask

  // ready driver, changes just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dith_ready = stall_mode ? lfsr[0] : 1'b1;
    pan_ready  = stall_mode ? lfsr[7] : 1'b1;
  end

  // monitor at falling edge: compares every transfer against the queues
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_d) chk("R8 dither hold", {15'd0, dith_valid, dith_data}, {15'd0, 1'b1, hold_dv});
      if (hold_p) chk("R8 panel hold", {15'd0, pan_valid, pan_data}, {15'd0, 1'b1, hold_pv});
      hold_d = dith_valid && !dith_ready; hold_dv = dith_data;
      hold_p = pan_valid && !pan_ready;   hold_pv = pan_data;
      if (dith_valid && dith_ready) begin
        if (exp_d.size() == 0) chk({cur_req, " R7 unexpected dither pixel"}, {16'd0, dith_data}, 32'hFFFF_FFFF);
        else chk({cur_req, " dither pixel"}, {16'd0, dith_data}, {16'd0, exp_d.pop_front()});
      end
      if (pan_valid && pan_ready) begin
        if (exp_p.size() == 0) chk({cur_req, " R7 unexpected panel pixel"}, {16'd0, pan_data}, 32'hFFFF_FFFF);
        else chk({cur_req, " panel pixel"}, {16'd0, pan_data}, {16'd0, exp_p.pop_front()});
      end
    end
  end

  task automatic push_exp(input logic [31:0] w);
    int lg = (depth_sel > 3'd4) ? 4 : int'(depth_sel);
    int b = 1 << lg;
    for (int i = 0; i < 32 / b; i++) begin
      logic [15:0] v;
      logic [15:0] e;
      v = 16'((w >> (i * b)) & ((32'h1 << b) - 1));
      if (lg == 4) begin
        if (panel_active) exp_p.push_back(v);
        else exp_d.push_back(v);
      end else begin
        e = pal_m[v[7:0]];
        if (mono) e = {8'h00, e[7:0]};
        exp_d.push_back(e);
      end
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    logic ok;
    push_exp(w);
    word_data = w; word_valid = 1'b1;
    forever begin
      @(negedge clk); ok = word_ready;
      sync();
      if (ok) break;
    end
    word_valid = 1'b0;
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [15:0] d);
    logic ok;
    pal_wr_addr = a; pal_wr_data = d; pal_wr_en = 1'b1;
    forever begin
      @(negedge clk); ok = pal_wr_ready;
      sync();
      if (ok) break;
    end
    pal_wr_en = 1'b0;
    pal_m[a] = d;
  endtask

  task automatic pulse_sof();
    sof = 1'b1; sync(); sof = 1'b0; sync();
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((exp_d.size() != 0 || exp_p.size() != 0) && t < 4000) begin sync(); t++; end
    chk({req, " all pixels delivered"}, exp_d.size() + exp_p.size(), 0);
    sync(); sync();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset valids", {30'd0, dith_valid, pan_valid}, 0);
    chk("R10 reset readies", {30'd0, word_ready, pal_wr_ready}, 32'd3);
    sync();
  endtask

  task automatic t_load();
    for (int i = 0; i < 256; i++)
      pal_write(8'(i), {8'(i * 7 + 3), 8'(i) ^ 8'hC3});
  endtask

  task automatic t_depth8();
    cur_req = "R1/R3"; depth_sel = 3'd3; panel_active = 1'b0; mono = 1'b0;
    send_word(32'h0302_0100);
    send_word(32'hFF80_7F01);
    send_word(32'hA5C3_0F10);
    drain("R3");
    depth_sel = 3'd2; cur_req = "R1";
    send_word(32'h0123_4567);
    send_word(32'hFEDC_BA98);
    drain("R1");
  endtask

  task automatic t_low_depth();
    cur_req = "R2";
    for (int d = 0; d < 3; d++) begin
      depth_sel = 3'(d);
      send_word(32'hFFFF_FFFF);
      send_word(32'h1234_5678);
      send_word(32'h8000_0001);
      drain("R2");
    end
  endtask

  task automatic t_mono();
    cur_req = "R4"; mono = 1'b1; depth_sel = 3'd3;
    send_word(32'hFFC3_5A00);
    send_word(32'h1122_3344);
    drain("R4");
    mono = 1'b0;
  endtask

  task automatic t_direct_passive();
    cur_req = "R5"; depth_sel = 3'd4; panel_active = 1'b0;
    send_word(32'hBEEF_1234);
    send_word(32'h0000_FFFF);
    drain("R5");
  endtask

  task automatic t_direct_active();
    cur_req = "R6"; depth_sel = 3'd4; panel_active = 1'b1;
    send_word(32'hCAFE_8001);
    send_word(32'h7FFF_0000);
    drain("R6");
  endtask

  task automatic t_pal_route();
    cur_req = "R7"; depth_sel = 3'd3; panel_active = 1'b1;
    send_word(32'h40C0_2090);
    drain("R7");
    panel_active = 1'b0;
  endtask

  task automatic t_stall();
    cur_req = "R8"; stall_mode = 1'b1;
    depth_sel = 3'd2;
    for (int i = 0; i < 6; i++) send_word(32'h9E37_79B9 * (i + 1));
    drain("R8");
    depth_sel = 3'd0;
    send_word(32'hA5A5_0F0F);
    drain("R8");
    depth_sel = 3'd4; panel_active = 1'b1;
    for (int i = 0; i < 4; i++) send_word(32'h1357_9BDF + 32'(i) * 32'h0101_0101);
    drain("R8");
    panel_active = 1'b0;
    for (int i = 0; i < 4; i++) send_word(32'h2468_ACE0 ^ (32'(i) << 8));
    drain("R8");
    stall_mode = 1'b0;
    sync(); sync();
  endtask

  task automatic t_holdoff();
    cur_req = "R9"; depth_sel = 3'd3; panel_active = 1'b0; mono = 1'b0;
    pulse_sof();
    send_word(32'h0000_0011);
    drain("R9");
    pal_wr_addr = 8'h11; pal_wr_data = 16'hBEEF; pal_wr_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 write held mid-frame", {31'd0, pal_wr_ready}, 0);
      sync();
    end
    send_word(32'h0000_0011);
    drain("R9 old entry still read");
    sof = 1'b1; sync(); sof = 1'b0;
    @(negedge clk);
    chk("R9 write released after sof", {31'd0, pal_wr_ready}, 1);
    sync();
    pal_wr_en = 1'b0;
    pal_m[8'h11] = 16'hBEEF;
    send_word(32'h0011_1100);
    drain("R9 new entry");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_load();
    t_depth8();
    t_low_depth();
    t_mono();
    t_direct_passive();
    t_direct_active();
    t_pal_route();
    t_stall();
    t_holdoff();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule